// File: doc/BRIEF.md
# Barrel Shifter with Carry-Out

This block forms the second ALU operand for a 32-bit RISC data path, together with the shifter carry that the logical ALU operations write into the carry flag. Each input beat carries a register value, a shift kind, the two possible sources of a shift amount (a 5-bit field from the instruction or the low byte of a register), the current carry flag, and a constant-operand mode. In constant-operand mode the shift inputs are not used. The operand is instead an 8-bit constant rotated right by an even amount.

The shift kinds differ in how they treat zero and large amounts. For an amount from the instruction field, zero has a special meaning: logical and arithmetic right shifts shift by the full width, and a rotate becomes a one-bit rotate through the carry flag. For an amount taken from a register, zero passes the value through unchanged. Larger register amounts are clamped, and a rotate whose amount is a multiple of 32 rotates by the full width.

Beats enter and leave through a valid/ready pair with one output register stage. `in_ready` is high whenever the output register is empty or is being drained in the same cycle. A beat is taken on a clock edge where `in_valid` and `in_ready` are both high. The beat's result is then held on the outputs, without change, until a clock edge where `out_ready` is high. Holding `out_ready` low therefore stalls the upstream side after one beat.

Top module: `bshift_unit`

## Requirements
- R1: After reset, `out_valid` is 0, `out_result` is 0 and `in_ready` is 1.
- R2: A beat taken at a clock edge is shown with `out_valid` high after that edge. While `out_valid` is high and `out_ready` is low, `out_result` and `out_carry` hold their values and `in_ready` is low.
- R3: Shift kind codes on `in_type` are 0 = shift left logical, 1 = shift right logical, 2 = shift right arithmetic, 3 = rotate right. For a nonzero effective amount n, the carry-out is the last bit shifted out: bit 32−n for left shifts, and bit n−1 for the right shifts and the rotate.
- R4: With `in_reg_src` = 0 and `in_imm_amt` = 0, a left shift passes the value through with carry-out equal to `in_carry`, and the two right shifts act as shifts by 32.
- R5: With `in_reg_src` = 0, `in_imm_amt` = 0 and rotate kind, the result is `{in_carry, in_operand[31:1]}` and the carry-out is `in_operand[0]`.
- R6: With `in_reg_src` = 1 and `in_reg_amt` = 0, every kind passes the value through with carry-out equal to `in_carry`. In this case `in_imm_amt` has no effect.
- R7: With `in_reg_src` = 1, left and right logical shifts use the register amount up to 32. Any amount above 32 gives result 0 and carry-out 0.
- R8: With `in_reg_src` = 1 and an arithmetic shift of 32 or more, every result bit and the carry-out equal `in_operand[31]`.
- R9: With `in_reg_src` = 1 and rotate kind with a nonzero amount, the rotation is by the amount's low 5 bits. If those 5 bits are zero, the value is unchanged and the carry-out is `in_operand[31]`.
- R10: With `in_const_mode` = 1, the result is `in_const` zero-extended and rotated right by twice `in_rot`. The inputs `in_operand`, `in_type`, `in_reg_src` and both amounts have no effect.
- R11: With `in_const_mode` = 1, the carry-out is bit 31 of the rotated constant when `in_rot` is nonzero, and `in_carry` when `in_rot` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Unit can take a beat |
| in_operand | input | 32 | Register value to be shifted |
| in_type | input | 2 | Shift kind (0 LSL, 1 LSR, 2 ASR, 3 ROR) |
| in_reg_src | input | 1 | 1 = amount from register byte, 0 = from instruction field |
| in_imm_amt | input | 5 | Shift amount from instruction field |
| in_reg_amt | input | 8 | Shift amount from register low byte |
| in_carry | input | 1 | Current carry flag |
| in_const_mode | input | 1 | 1 = rotated-constant operand |
| in_const | input | 8 | Constant for constant-operand mode |
| in_rot | input | 4 | Rotate field, rotation = 2 × value |
| out_valid | output | 1 | Result beat present |
| out_ready | input | 1 | Downstream takes the result |
| out_result | output | 32 | Shifted operand |
| out_carry | output | 1 | Shifter carry-out |

## Verification
Each shift kind is first driven with a nonzero field amount, on a value whose carry bit differs from its neighbours. This separates a carry taken from the last bit shifted out from a carry off by one position. The amount zero is then applied from both sources and for all four kinds, so the three field cases (pass, shift by 32, rotate through carry) are told apart from register-source pass-through. Register amounts of exactly 32, just above 32, large values and multiples of 32 for the rotate separate the clamping rules of each kind. Constant-mode beats, with unused fields set to random values, show that only the constant, the rotate field and the incoming carry matter. Many randomized beats are then compared against a bit-serial model.

// File: rtl/bshift_pkg.sv
package bshift_pkg;

  typedef enum logic [1:0] {
    SK_LSL = 2'd0,
    SK_LSR = 2'd1,
    SK_ASR = 2'd2,
    SK_ROR = 2'd3
  } shift_kind_e;

  typedef enum logic [1:0] {
    ACT_PASS  = 2'd0,
    ACT_SHIFT = 2'd1,
    ACT_RRX   = 2'd2
  } shift_act_e;

endpackage

// File: rtl/bshift_amount_decode.sv
module bshift_amount_decode
  import bshift_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int IMM_AMT_W = 5,
  parameter int REG_AMT_W = 8,
  parameter int NW        = 6
) (
  input  shift_kind_e          kind,
  input  logic                 reg_src,
  input  logic [IMM_AMT_W-1:0] imm_amt,
  input  logic [REG_AMT_W-1:0] reg_amt,
  output shift_act_e           act,
  output logic [NW-1:0]        amt
);
  localparam logic [NW-1:0]        N_FULL   = NW'(DATA_W);
  localparam logic [NW-1:0]        N_OVER   = NW'(DATA_W + 1);
  localparam logic [REG_AMT_W-1:0] REG_FULL = REG_AMT_W'(DATA_W);

  logic [IMM_AMT_W-1:0] reg_low;
  assign reg_low = reg_amt[IMM_AMT_W-1:0];

  always_comb begin
    act = ACT_SHIFT;
    amt = '0;
    if (reg_src) begin
      if (reg_amt == '0) begin
        act = ACT_PASS;
      end else begin
        unique case (kind)
          SK_LSL, SK_LSR: amt = (reg_amt > REG_FULL) ? N_OVER : NW'(reg_amt);
          SK_ASR:         amt = (reg_amt >= REG_FULL) ? N_FULL : NW'(reg_amt);
          default:        amt = (reg_low == '0) ? N_FULL : NW'(reg_low);
        endcase
      end
    end else begin
      if (imm_amt == '0) begin
        unique case (kind)
          SK_LSL:         act = ACT_PASS;
          SK_LSR, SK_ASR: amt = N_FULL;
          default:        act = ACT_RRX;
        endcase
      end else begin
        amt = NW'(imm_amt);
      end
    end
  end
endmodule

// File: rtl/bshift_datapath.sv
module bshift_datapath
  import bshift_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NW     = 6
) (
  input  shift_kind_e       kind,
  input  shift_act_e        act,
  input  logic [NW-1:0]     amt,
  input  logic [DATA_W-1:0] x,
  input  logic              cin,
  output logic [DATA_W-1:0] res,
  output logic              cout
);
  localparam logic [NW-1:0] N_FULL = NW'(DATA_W);

  logic [DATA_W:0]        left_w;
  logic [DATA_W:0]        right_w;
  logic signed [DATA_W:0] arith_w;
  logic [DATA_W-1:0]      rot_w;
  logic [NW-1:0]          back_amt;

  // one guard bit catches the last bit shifted out
  assign left_w   = {1'b0, x} << amt;
  assign right_w  = {x, 1'b0} >> amt;
  assign arith_w  = $signed({x, 1'b0}) >>> amt;
  assign back_amt = N_FULL - amt;
  assign rot_w    = (x >> amt) | (x << back_amt);

  always_comb begin
    res  = x;
    cout = cin;
    unique case (act)
      ACT_RRX: begin
        res  = {cin, x[DATA_W-1:1]};
        cout = x[0];
      end
      ACT_SHIFT: begin
        unique case (kind)
          SK_LSL: begin res = left_w[DATA_W-1:0];  cout = left_w[DATA_W]; end
          SK_LSR: begin res = right_w[DATA_W:1];   cout = right_w[0];     end
          SK_ASR: begin res = arith_w[DATA_W:1];   cout = arith_w[0];     end
          default: begin res = rot_w;              cout = rot_w[DATA_W-1]; end
        endcase
      end
      default: begin
        res  = x;
        cout = cin;
      end
    endcase
  end
endmodule

// File: rtl/bshift_const_rot.sv
module bshift_const_rot #(
  parameter int DATA_W = 32,
  parameter int CONST_W = 8,
  parameter int ROT_W  = 4,
  parameter int NW     = 6
) (
  input  logic [CONST_W-1:0] k,
  input  logic [ROT_W-1:0]   rot,
  input  logic               cin,
  output logic [DATA_W-1:0]  res,
  output logic               cout
);
  localparam logic [NW-1:0] N_FULL = NW'(DATA_W);

  logic [DATA_W-1:0] k_ext;
  logic [NW-1:0]     sh;
  logic [NW-1:0]     sh_back;

  assign k_ext   = DATA_W'(k);
  assign sh      = NW'({rot, 1'b0});
  assign sh_back = N_FULL - sh;
  assign res     = (k_ext >> sh) | (k_ext << sh_back);
  assign cout    = (rot != '0) ? res[DATA_W-1] : cin;
endmodule

// File: rtl/bshift_unit.sv
module bshift_unit
  import bshift_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int IMM_AMT_W = 5,
  parameter int REG_AMT_W = 8,
  parameter int CONST_W   = 8,
  parameter int ROT_W     = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [DATA_W-1:0]    in_operand,
  input  logic [1:0]           in_type,
  input  logic                 in_reg_src,
  input  logic [IMM_AMT_W-1:0] in_imm_amt,
  input  logic [REG_AMT_W-1:0] in_reg_amt,
  input  logic                 in_carry,
  input  logic                 in_const_mode,
  input  logic [CONST_W-1:0]   in_const,
  input  logic [ROT_W-1:0]     in_rot,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [DATA_W-1:0]    out_result,
  output logic                 out_carry
);
  localparam int NW = $clog2(DATA_W + 2);

  shift_kind_e       kind;
  shift_act_e        act;
  logic [NW-1:0]     amt;
  logic [DATA_W-1:0] sh_res, k_res, nxt_res;
  logic              sh_c, k_c, nxt_c;
  logic              take;

  assign kind = shift_kind_e'(in_type);

  bshift_amount_decode #(
    .DATA_W(DATA_W), .IMM_AMT_W(IMM_AMT_W), .REG_AMT_W(REG_AMT_W), .NW(NW)
  ) dec_i (
    .kind(kind), .reg_src(in_reg_src), .imm_amt(in_imm_amt),
    .reg_amt(in_reg_amt), .act(act), .amt(amt)
  );

  bshift_datapath #(.DATA_W(DATA_W), .NW(NW)) dp_i (
    .kind(kind), .act(act), .amt(amt), .x(in_operand), .cin(in_carry),
    .res(sh_res), .cout(sh_c)
  );

  bshift_const_rot #(
    .DATA_W(DATA_W), .CONST_W(CONST_W), .ROT_W(ROT_W), .NW(NW)
  ) kr_i (
    .k(in_const), .rot(in_rot), .cin(in_carry), .res(k_res), .cout(k_c)
  );

  assign nxt_res  = in_const_mode ? k_res : sh_res;
  assign nxt_c    = in_const_mode ? k_c   : sh_c;
  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_result <= '0;
      out_carry  <= 1'b0;
    end else if (take) begin
      out_valid  <= 1'b1;
      out_result <= nxt_res;
      out_carry  <= nxt_c;
    end else if (out_ready) begin
      out_valid  <= 1'b0;
    end
  end
endmodule

// File: rtl/bshift_unit_chk.sv
module bshift_unit_chk #(
  parameter int DATA_W    = 32,
  parameter int IMM_AMT_W = 5,
  parameter int REG_AMT_W = 8,
  parameter int ROT_W     = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_valid,
  input logic                 in_ready,
  input logic [DATA_W-1:0]    in_operand,
  input logic [1:0]           in_type,
  input logic                 in_reg_src,
  input logic [IMM_AMT_W-1:0] in_imm_amt,
  input logic [REG_AMT_W-1:0] in_reg_amt,
  input logic                 in_carry,
  input logic                 in_const_mode,
  input logic [ROT_W-1:0]     in_rot,
  input logic                 out_valid,
  input logic                 out_ready,
  input logic [DATA_W-1:0]    out_result,
  input logic                 out_carry
);
  localparam logic [REG_AMT_W-1:0] REG_FULL = REG_AMT_W'(DATA_W);

  logic acc_shift;
  assign acc_shift = in_valid && in_ready && !in_const_mode;

  // R2
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_result) && $stable(out_carry)));

  // R2
  accept_show_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  // R2
  stall_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  // R5
  rrx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_shift && !in_reg_src && in_imm_amt == '0 && in_type == 2'd3)
    |=> (out_result == {$past(in_carry), $past(in_operand[DATA_W-1:1])}
         && out_carry == $past(in_operand[0])));

  // R6
  reg_zero_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_shift && in_reg_src && in_reg_amt == '0)
    |=> (out_result == $past(in_operand) && out_carry == $past(in_carry)));

  // R7
  logical_over_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_shift && in_reg_src && in_reg_amt > REG_FULL && in_type[1] == 1'b0)
    |=> (out_result == '0 && !out_carry));

  // R8
  arith_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_shift && in_reg_src && in_reg_amt >= REG_FULL && in_type == 2'd2)
    |=> (out_result == {DATA_W{$past(in_operand[DATA_W-1])}}
         && out_carry == $past(in_operand[DATA_W-1])));

  // R11
  const_keep_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_const_mode && in_rot == '0)
    |=> (out_carry == $past(in_carry)));
endmodule

bind bshift_unit bshift_unit_chk #(
  .DATA_W(DATA_W), .IMM_AMT_W(IMM_AMT_W), .REG_AMT_W(REG_AMT_W), .ROT_W(ROT_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_operand(in_operand), .in_type(in_type), .in_reg_src(in_reg_src),
  .in_imm_amt(in_imm_amt), .in_reg_amt(in_reg_amt), .in_carry(in_carry),
  .in_const_mode(in_const_mode), .in_rot(in_rot), .out_valid(out_valid),
  .out_ready(out_ready), .out_result(out_result), .out_carry(out_carry)
);

// File: tb/bshift_unit_tb_top.sv
module bshift_unit_tb_top;

  typedef struct packed {
    logic [1:0]  ty;
    logic        rs;
    logic [4:0]  ia;
    logic [7:0]  ra;
    logic        ci;
    logic        cm;
    logic [7:0]  k;
    logic [3:0]  rot;
    logic [31:0] op;
    logic [31:0] er;
    logic        ec;
    logic [7:0]  rq;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t TBL [NV] = '{
    '{2'd0, 1'b0, 5'd4, 8'd0,   1'b0, 1'b0, 8'h00, 4'h0, 32'hF000_0001, 32'h0000_0010, 1'b1, 8'd3},  // R3 lsl
    '{2'd1, 1'b0, 5'd1, 8'd0,   1'b0, 1'b0, 8'h00, 4'h0, 32'h0000_0003, 32'h0000_0001, 1'b1, 8'd3},  // R3 lsr
    '{2'd2, 1'b0, 5'd4, 8'd0,   1'b0, 1'b0, 8'h00, 4'h0, 32'h8000_0010, 32'hF800_0001, 1'b0, 8'd3},  // R3 asr
    '{2'd3, 1'b0, 5'd8, 8'd0,   1'b0, 1'b0, 8'h00, 4'h0, 32'h1234_5678, 32'h7812_3456, 1'b0, 8'd3},  // R3 ror
    '{2'd0, 1'b0, 5'd0, 8'd9,   1'b1, 1'b0, 8'h00, 4'h0, 32'hDEAD_BEEF, 32'hDEAD_BEEF, 1'b1, 8'd4},  // R4
    '{2'd1, 1'b0, 5'd0, 8'd0,   1'b0, 1'b0, 8'h00, 4'h0, 32'h8000_0000, 32'h0000_0000, 1'b1, 8'd4},  // R4
    '{2'd2, 1'b0, 5'd0, 8'd0,   1'b0, 1'b0, 8'h00, 4'h0, 32'h8000_0000, 32'hFFFF_FFFF, 1'b1, 8'd4},  // R4
    '{2'd3, 1'b0, 5'd0, 8'd0,   1'b1, 1'b0, 8'h00, 4'h0, 32'h0000_0003, 32'h8000_0001, 1'b1, 8'd5},  // R5
    '{2'd0, 1'b1, 5'd5, 8'd0,   1'b1, 1'b0, 8'h00, 4'h0, 32'h1234_5678, 32'h1234_5678, 1'b1, 8'd6},  // R6
    '{2'd3, 1'b1, 5'd7, 8'd0,   1'b0, 1'b0, 8'h00, 4'h0, 32'h8000_0001, 32'h8000_0001, 1'b0, 8'd6},  // R6
    '{2'd0, 1'b1, 5'd0, 8'd32,  1'b0, 1'b0, 8'h00, 4'h0, 32'h0000_0001, 32'h0000_0000, 1'b1, 8'd7},  // R7
    '{2'd1, 1'b1, 5'd0, 8'd40,  1'b1, 1'b0, 8'h00, 4'h0, 32'hFFFF_FFFF, 32'h0000_0000, 1'b0, 8'd7},  // R7
    '{2'd1, 1'b1, 5'd0, 8'd32,  1'b0, 1'b0, 8'h00, 4'h0, 32'h8000_0000, 32'h0000_0000, 1'b1, 8'd7},  // R7
    '{2'd1, 1'b1, 5'd0, 8'd5,   1'b0, 1'b0, 8'h00, 4'h0, 32'h0000_0030, 32'h0000_0001, 1'b1, 8'd7},  // R7
    '{2'd2, 1'b1, 5'd0, 8'd200, 1'b0, 1'b0, 8'h00, 4'h0, 32'h8000_0000, 32'hFFFF_FFFF, 1'b1, 8'd8},  // R8
    '{2'd3, 1'b1, 5'd0, 8'd64,  1'b0, 1'b0, 8'h00, 4'h0, 32'h8000_0002, 32'h8000_0002, 1'b1, 8'd9},  // R9
    '{2'd3, 1'b1, 5'd0, 8'd33,  1'b0, 1'b0, 8'h00, 4'h0, 32'h0000_0003, 32'h8000_0001, 1'b1, 8'd9},  // R9
    '{2'd0, 1'b0, 5'd0, 8'd0,   1'b0, 1'b1, 8'hFF, 4'h4, 32'h1234_5678, 32'hFF00_0000, 1'b1, 8'd10}, // R10
    '{2'd2, 1'b0, 5'd0, 8'd0,   1'b0, 1'b1, 8'h02, 4'h1, 32'h0000_0000, 32'h8000_0000, 1'b1, 8'd10}, // R10
    '{2'd1, 1'b1, 5'd3, 8'd7,   1'b1, 1'b1, 8'h3F, 4'h0, 32'hAAAA_AAAA, 32'h0000_003F, 1'b1, 8'd11}  // R11
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_operand = '0;
  logic [1:0]  in_type = '0;
  logic        in_reg_src = 1'b0;
  logic [4:0]  in_imm_amt = '0;
  logic [7:0]  in_reg_amt = '0;
  logic        in_carry = 1'b0;
  logic        in_const_mode = 1'b0;
  logic [7:0]  in_const = '0;
  logic [3:0]  in_rot = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_result;
  logic        out_carry;

  int n_chk = 0;
  int n_err = 0;

  always #4 clk = ~clk;

  bshift_unit dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_operand(in_operand), .in_type(in_type), .in_reg_src(in_reg_src),
    .in_imm_amt(in_imm_amt), .in_reg_amt(in_reg_amt), .in_carry(in_carry),
    .in_const_mode(in_const_mode), .in_const(in_const), .in_rot(in_rot),
    .out_valid(out_valid), .out_ready(out_ready), .out_result(out_result),
    .out_carry(out_carry)
  );

  task automatic check(input bit ok, input string req, input logic [32:0] act_v,
                       input logic [32:0] exp_v);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act_v, exp_v);
    end
  endtask

  // bit-serial reference built from the requirements
  function automatic logic [32:0] model(input vec_t v);
    logic [31:0] x;
    logic c;
    int n;
    x = v.op;
    c = v.ci;
    if (v.cm) begin
      x = {24'd0, v.k};
      for (int i = 0; i < 2 * int'(v.rot); i++) x = {x[0], x[31:1]};
      if (v.rot != 0) c = x[31];
      return {c, x};
    end
    if (v.rs) begin
      if (v.ra == 0) return {c, x};
      if (v.ty == 2'd3) n = (v.ra[4:0] == 0) ? 32 : int'(v.ra[4:0]);
      else if (v.ty == 2'd2) n = (v.ra >= 32) ? 32 : int'(v.ra);
      else n = (v.ra > 32) ? 33 : int'(v.ra);
    end else begin
      if (v.ia == 0) begin
        if (v.ty == 2'd0) return {c, x};
        if (v.ty == 2'd3) return {x[0], c, x[31:1]};
        n = 32;
      end else n = int'(v.ia);
    end
    for (int i = 0; i < n; i++) begin
      case (v.ty)
        2'd0: begin c = x[31]; x = {x[30:0], 1'b0}; end
        2'd1: begin c = x[0];  x = {1'b0, x[31:1]}; end
        2'd2: begin c = x[0];  x = {x[31], x[31:1]}; end
        default: begin c = x[0]; x = {x[0], x[31:1]}; end
      endcase
    end
    return {c, x};
  endfunction

  task automatic drive(input vec_t v);
    in_type = v.ty; in_reg_src = v.rs; in_imm_amt = v.ia; in_reg_amt = v.ra;
    in_carry = v.ci; in_const_mode = v.cm; in_const = v.k; in_rot = v.rot;
    in_operand = v.op;
  endtask

  task automatic run_vec(input vec_t v, input logic [32:0] exp_v, input string req);
    @(negedge clk);
    drive(v);
    in_valid = 1'b1;
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid && {out_carry, out_result} == exp_v, req,
          {out_carry, out_result}, exp_v);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++; n_chk++;
    $display("FAIL R2 watchdog actual=hung expected=done");
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    vec_t v;
    vec_t a;
    vec_t b;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    check(!out_valid && in_ready && out_result == '0, "R1",
          {out_valid, out_result}, 33'd0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++)
      run_vec(TBL[i], {TBL[i].ec, TBL[i].er}, $sformatf("R%0d vec%0d", TBL[i].rq, i));

    // R3 randomized beats against the model (also covers R4-R11 paths)
    for (int i = 0; i < 300; i++) begin
      v = vec_t'({$urandom, $urandom, $urandom});
      if (i % 3 == 0) v.ra = 8'($urandom_range(0, 70));
      v.cm = (i % 5 == 0);
      run_vec(v, model(v), "R3 random");
    end

    // R2 back-pressure
    a = TBL[0];
    b = TBL[3];
    @(negedge clk);
    drive(a); in_valid = 1'b1; out_ready = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check(out_valid && !in_ready && out_result == a.er, "R2 first beat",
          {out_carry, out_result}, {a.ec, a.er});
    drive(b);
    @(posedge clk);
    @(negedge clk);
    check(out_result == a.er && out_carry == a.ec && !in_ready, "R2 hold",
          {out_carry, out_result}, {a.ec, a.er});
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid && out_result == b.er && out_carry == b.ec, "R2 second beat",
          {out_carry, out_result}, {b.ec, b.er});
    @(posedge clk);
    @(negedge clk);
    check(!out_valid && in_ready, "R2 drain", {32'd0, out_valid}, 33'd0);

    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule